// File: doc/BRIEF.md
# Configurable 8/16-bit Prescaled Timer

An up-counting timer whose width is chosen at run time: it counts either over a full 16-bit word or only over its low byte. Each count event comes from one of two sources. The first is an internal tick enable. The second is an external pin, which passes through a synchroniser and is counted on its rising or falling edge. A power-of-two prescaler divides the events by 2 up to 256, or it can be bypassed.

When the counter wraps to zero it raises a sticky overflow flag. Counting stops until software clears that flag. Software can load the counter at any time through a write strobe, and the load also restarts the prescaler phase. The live count is always visible on an output port.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the count reads 0x0000 and the overflow flag reads 0.
- R2: With the internal source selected (`src_ext_i`=0) and the prescaler bypassed, the count rises by one on each clock where `tick_i` is 1 and holds on each clock where it is 0.
- R3: With the prescaler in use, selection code s (0..7) gives one count every 2^(s+1) events, counted from the last counter write.
- R4: In 8-bit mode (`wide_i`=0) only bits 7:0 count and bits 15:8 hold their value. The flag sets when bits 7:0 wrap from 0xFF to 0x00.
- R5: In 16-bit mode (`wide_i`=1) a carry passes from bit 7 into bit 8 without setting the flag. The flag sets only when the count wraps from 0xFFFF to 0x0000.
- R6: While the flag is 1, the count and the prescaler are frozen and the flag stays 1. A one-cycle `flag_clr_i` pulse clears the flag, and counting then resumes.
- R7: `wr_en_i` loads `wr_data_i` into the count on the next edge, overriding a same-cycle increment, and clears the prescaler phase.
- R8: With the external source selected, one count is made per pin edge of the chosen polarity: rising when `ext_fall_i`=0, falling when `ext_fall_i`=1.
- R9: The unselected source has no effect. `tick_i` is ignored when the external source is selected, and the pin is ignored when the internal source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Internal count enable |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| src_ext_i | input | 1 | 1 selects the external pin as event source |
| ext_fall_i | input | 1 | 1 counts falling pin edges, 0 rising |
| wide_i | input | 1 | 1 selects 16-bit mode, 0 selects 8-bit mode |
| presc_bypass_i | input | 1 | 1 bypasses the prescaler (ratio 1:1) |
| presc_sel_i | input | 3 | Prescale code s, ratio 1:2^(s+1) |
| wr_en_i | input | 1 | Counter write strobe |
| wr_data_i | input | 16 | Counter write value |
| flag_clr_i | input | 1 | Overflow flag clear strobe |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest condition to reach is an overflow under the largest prescale ratio or in the middle of an 8-bit wrap. From reset, reaching it by counting alone would take tens of thousands of events. The stimulus therefore preloads the counter through the write strobe to a few counts below the wrap point, then supplies just enough ticks to cross it and some more. This shows the freeze as well as the wrap. A separate sequence leaves the prescaler partly advanced and then writes the counter, to show that the phase restarts.

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int PRE_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        ext_pin_i,
  input  logic        src_ext_i,
  input  logic        ext_fall_i,
  input  logic        wide_i,
  input  logic        presc_bypass_i,
  input  logic [2:0]  presc_sel_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        flag_clr_i,
  output logic [15:0] count_o,
  output logic        ovf_o
);

  logic [2:0]       pin_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_mask;
  logic [15:0]      cnt_q, cnt_nx;
  logic             ovf_q;
  logic             ext_evt, evt, run, bump, wrap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= '0;
    else        pin_q <= {pin_q[1:0], ext_pin_i};

  assign ext_evt  = ext_fall_i ? (~pin_q[1] & pin_q[2]) : (pin_q[1] & ~pin_q[2]);
  assign evt      = src_ext_i ? ext_evt : tick_i;
  assign run      = evt & ~ovf_q;
  assign pre_mask = ~({PRE_W{1'b1}} << ({1'b0, presc_sel_i} + 4'd1));
  assign bump     = presc_bypass_i ? run : (run && ((pre_q & pre_mask) == pre_mask));
  assign wrap     = wide_i ? (&cnt_q) : (&cnt_q[7:0]);
  assign cnt_nx   = wide_i ? cnt_q + 16'd1 : {cnt_q[15:8], cnt_q[7:0] + 8'd1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     pre_q <= '0;
    else if (wr_en_i)               pre_q <= '0;
    else if (run && !presc_bypass_i) pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt_q <= '0;
    else if (wr_en_i) cnt_q <= wr_data_i;
    else if (bump)    cnt_q <= cnt_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       ovf_q <= 1'b0;
    else if (bump && wrap && !wr_en_i) ovf_q <= 1'b1;
    else if (flag_clr_i)              ovf_q <= 1'b0;

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !wr_en_i) |=> $stable(cnt_q));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !flag_clr_i) |=> ovf_q);
  p_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (cnt_q == $past(wr_data_i)));
  p_hold_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !wide_i) |=> (cnt_q[15:8] == $past(cnt_q[15:8])));
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (cnt_q[7:0] == 8'h00));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && wide_i && !(&cnt_q)) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 16'd1));

endmodule

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
  logic        clk = 0, rst_n = 0;
  logic        tick_i = 0, ext_pin_i = 0, src_ext_i = 0, ext_fall_i = 0;
  logic        wide_i = 1, presc_bypass_i = 1, wr_en_i = 0, flag_clr_i = 0;
  logic [2:0]  presc_sel_i = 0;
  logic [15:0] wr_data_i = 0;
  logic [15:0] count_o;
  logic        ovf_o;
  int tests = 0, fails = 0;

  always #2.5ns clk = ~clk;

  prescaled_timer i_prescaled_timer (.*);

  typedef struct packed {
    logic wide; logic byp; logic [2:0] sel;
    logic [15:0] pre; logic [15:0] n; logic [15:0] exp; logic flag;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b1, 1'b1, 3'd0, 16'h0010, 16'd5,   16'h0015, 1'b0}, // R2
    '{1'b1, 1'b0, 3'd0, 16'h0000, 16'd7,   16'h0003, 1'b0}, // R3 /2
    '{1'b1, 1'b0, 3'd2, 16'h0100, 16'd40,  16'h0105, 1'b0}, // R3 /8
    '{1'b1, 1'b0, 3'd7, 16'h0000, 16'd600, 16'h0002, 1'b0}, // R3 /256
    '{1'b0, 1'b1, 3'd0, 16'h12FD, 16'd3,   16'h1200, 1'b1}, // R4 wrap
    '{1'b0, 1'b1, 3'd0, 16'h12FD, 16'd9,   16'h1200, 1'b1}, // R6 freeze
    '{1'b1, 1'b1, 3'd0, 16'h00FE, 16'd3,   16'h0101, 1'b0}, // R5 carry
    '{1'b1, 1'b1, 3'd0, 16'hFFFE, 16'd5,   16'h0000, 1'b1}, // R5 wrap
    '{1'b0, 1'b0, 3'd1, 16'hAAFF, 16'd4,   16'hAA00, 1'b1}  // R4 /4
  };

  task automatic check(string req, logic [15:0] c, logic f);
    tests++;
    if (count_o !== c || ovf_o !== f) begin
      fails++;
      $display("FAIL %s: count=%h ovf=%b expected count=%h ovf=%b", req, count_o, ovf_o, c, f);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [15:0] v);
    wr_data_i = v; wr_en_i = 1; cyc(1); wr_en_i = 0;
  endtask

  task automatic clr();
    flag_clr_i = 1; cyc(1); flag_clr_i = 0;
  endtask

  task automatic ticks(int n);
    tick_i = 1; cyc(n); tick_i = 0;
  endtask

  task automatic pulse(int n);
    for (int k = 0; k < n; k++) begin
      ext_pin_i = 1; cyc(4); ext_pin_i = 0; cyc(4);
    end
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3);
    check("R1 reset", 16'h0000, 1'b0);
    rst_n = 1; cyc(2);
    check("R1 after release", 16'h0000, 1'b0);

    for (int i = 0; i < 9; i++) begin
      wide_i = VEC[i].wide; presc_bypass_i = VEC[i].byp; presc_sel_i = VEC[i].sel;
      load(VEC[i].pre);
      ticks(int'(VEC[i].n));
      check($sformatf("vector %0d (R2-R6)", i), VEC[i].exp, VEC[i].flag);
      clr();
    end

    // R6: resume after clear
    wide_i = 1; presc_bypass_i = 1;
    load(16'hFFFF); ticks(1);
    check("R6 overflow", 16'h0000, 1'b1);
    ticks(3);
    check("R6 frozen", 16'h0000, 1'b1);
    clr(); ticks(2);
    check("R6 resume", 16'h0002, 1'b0);
    tick_i = 0; cyc(3);
    check("R2 idle hold", 16'h0002, 1'b0);

    // R7: write overrides increment
    tick_i = 1; wr_data_i = 16'h4321; wr_en_i = 1; cyc(1); wr_en_i = 0; tick_i = 0;
    check("R7 priority", 16'h4321, 1'b0);

    // R7: write restarts prescaler phase
    presc_bypass_i = 0; presc_sel_i = 3'd1;
    load(16'h0000); ticks(3); load(16'h0000); ticks(3);
    check("R7 phase cleared", 16'h0000, 1'b0);
    ticks(1);
    check("R7 first count", 16'h0001, 1'b0);

    // R9: pin ignored on internal source
    presc_bypass_i = 1; load(16'h0000);
    pulse(3);
    check("R9 pin ignored", 16'h0000, 1'b0);

    // R8: external rising, R9 tick ignored
    src_ext_i = 1; ext_fall_i = 0; cyc(2);
    load(16'h0000);
    tick_i = 1; pulse(3); tick_i = 0;
    check("R8/R9 rising edges", 16'h0003, 1'b0);
    ext_pin_i = 1; cyc(4);
    check("R8 rising only", 16'h0004, 1'b0);
    ext_pin_i = 0; cyc(4);
    check("R8 fall not counted", 16'h0004, 1'b0);

    // R8: external falling
    ext_fall_i = 1; cyc(1);
    load(16'h0000);
    ext_pin_i = 1; cyc(4);
    check("R8 rise not counted", 16'h0000, 1'b0);
    ext_pin_i = 0; cyc(4);
    check("R8 falling edge", 16'h0001, 1'b0);
    pulse(2);
    check("R8 falling edges", 16'h0003, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule